// File: doc/BRIEF.md
# ECC Error Reporting and Capture Unit

This block sits next to the ECC checkers of an on-chip RAM and an on-chip flash. Each memory drives two one-cycle strobes into it: one for a single-bit error that the checker corrected, and one for a multi-bit error it could not correct. With each strobe the memory also supplies the access address, the access attributes, the data word and the number of the bus master that made the access. The block gates these four error classes with a set of reporting enables. An enabled event sets a sticky status flag and raises one combined interrupt request, so software is told about the error. The event also records the details of the faulting access in a capture record. RAM and flash each have their own record.

A non-correctable event is reported from its strobe alone. Nothing has to come back from the requesting master. So an error on an access that the master later throws away is still flagged: a speculative fetch that is discarded, or a posted write. Software reaches the enables, the flags and both capture records through a small register port. Writes take effect on the clock edge. Reads are combinational from the register address. The asynchronous reset is released through a two-stage synchronizer. The block therefore stays idle for two clock edges after the reset input rises.

Top module: `ecc_rpt_unit`

## Requirements
- R1: The configuration register is at register address 0 and is 8 bits wide. In LSB-0 numbering, bit 5 enables RAM single-bit reporting, bit 4 enables flash single-bit reporting, bit 1 enables RAM non-correctable reporting and bit 0 enables flash non-correctable reporting. All other bits read 0, and all four enables are 0 after reset.
- R2: When RAM single-bit reporting is enabled, a RAM correction strobe sets status bit 5 on that clock edge. The status register is at address 1.
- R3: When flash single-bit reporting is enabled, a flash correction strobe sets status bit 4.
- R4: When the matching enable is set, a RAM non-correctable strobe sets status bit 1 and a flash non-correctable strobe sets status bit 0. No other handshake from the access is needed.
- R5: A reported RAM event loads the RAM record and a reported flash event loads the flash record. RAM address, info and data are at register addresses 2, 3 and 4; flash address, info and data are at 5, 6 and 7. The info word holds the attributes in bits 7:0, the master number in bits 11:8 and, in bit 16, a 1 when the captured event was non-correctable. The other memory's record is left unchanged.
- R6: An event whose enable is clear changes neither the status flags nor the capture records.
- R7: Status flags are sticky. Writing 1 to a status bit clears that flag, and writing 0 has no effect. If a flag is set and cleared in the same cycle, the set wins.
- R8: The interrupt output is high exactly when at least one status flag is set.
- R9: If a memory reports a single-bit and a non-correctable event in the same cycle and both are enabled, both flags are set and the record holds info bit 16 = 1.
- R10: A later reported event of the same memory overwrites that memory's record, and reads return the latest values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ram_sbc_i | input | 1 | RAM single-bit correction strobe |
| ram_nce_i | input | 1 | RAM non-correctable error strobe |
| ram_addr_i | input | ADDR_W | RAM access address |
| ram_attr_i | input | ATTR_W | RAM access attributes |
| ram_data_i | input | DATA_W | RAM access data |
| ram_mid_i | input | MID_W | RAM access bus master number |
| fl_sbc_i | input | 1 | Flash single-bit correction strobe |
| fl_nce_i | input | 1 | Flash non-correctable error strobe |
| fl_addr_i | input | ADDR_W | Flash access address |
| fl_attr_i | input | ATTR_W | Flash access attributes |
| fl_data_i | input | DATA_W | Flash access data |
| fl_mid_i | input | MID_W | Flash access bus master number |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| irq_o | output | 1 | Combined ECC interrupt request |

## Verification
The assertions assume that the error strobes are already synchronous to the clock and are held for a single cycle per event. They also assume that the address, attribute, data and master buses are valid in the same cycle as the strobe. The stimulus drives every strobe and bus change half a cycle before the capturing edge and drops the strobes again after one edge. It issues register writes the same way, including one write that clears a flag in the same cycle an event sets it. The stimulus keeps all strobes low during reset and during the synchronizer window.

// File: rtl/ecc_rpt_pkg.sv
package ecc_rpt_pkg;

  localparam int NCLS   = 4;
  localparam int NMEM   = 2;
  localparam int REG_AW = 3;
  localparam int REG_DW = 32;

  // event class indices into the internal enable and flag vectors
  localparam int CLS_FL_NC  = 0;
  localparam int CLS_RAM_NC = 1;
  localparam int CLS_FL_SB  = 2;
  localparam int CLS_RAM_SB = 3;

  // register bit position (LSB-0) of each class in config and status words
  localparam int CLS_POS [NCLS] = '{0, 1, 4, 5};

  // per memory (0 = RAM, 1 = flash) class of its single-bit and non-correctable events
  localparam int MEM_SB_CLS [NMEM] = '{CLS_RAM_SB, CLS_FL_SB};
  localparam int MEM_NC_CLS [NMEM] = '{CLS_RAM_NC, CLS_FL_NC};

  // register addresses
  localparam logic [REG_AW-1:0] RA_CFG      = 3'd0;
  localparam logic [REG_AW-1:0] RA_STAT     = 3'd1;
  localparam logic [REG_AW-1:0] RA_RAM_ADDR = 3'd2;
  localparam logic [REG_AW-1:0] RA_RAM_INFO = 3'd3;
  localparam logic [REG_AW-1:0] RA_RAM_DATA = 3'd4;
  localparam logic [REG_AW-1:0] RA_FL_ADDR  = 3'd5;
  localparam logic [REG_AW-1:0] RA_FL_INFO  = 3'd6;
  localparam logic [REG_AW-1:0] RA_FL_DATA  = 3'd7;

  // info word layout
  localparam int INFO_ATTR_LSB = 0;
  localparam int INFO_MID_LSB  = 8;
  localparam int INFO_NC_BIT   = 16;

endpackage

// File: rtl/ecc_rpt_enables.sv
module ecc_rpt_enables
  import ecc_rpt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we_i,
  input  logic [NCLS-1:0] wbits_i,
  output logic [NCLS-1:0] en_o
);

  logic [NCLS-1:0] en_q;
  logic [NCLS-1:0] en_d;

  always_comb begin
    en_d = wbits_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (we_i) begin
      en_q <= en_d;
    end
  end

  assign en_o = en_q;

endmodule

// File: rtl/ecc_rpt_flags.sv
module ecc_rpt_flags
  import ecc_rpt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCLS-1:0] set_i,
  input  logic [NCLS-1:0] clr_i,
  output logic [NCLS-1:0] flag_o,
  output logic            any_o
);

  logic [NCLS-1:0] flag_q;
  logic [NCLS-1:0] flag_d;
  logic            upd;

  always_comb begin
    // set takes priority over a write-one-to-clear in the same cycle
    flag_d = (flag_q & ~clr_i) | set_i;
    upd    = |{set_i, clr_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
    end else if (upd) begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;
  assign any_o  = |flag_q;

endmodule

// File: rtl/ecc_rpt_capture.sv
module ecc_rpt_capture #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int ATTR_W = 8,
  parameter int MID_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sb_i,
  input  logic              nc_i,
  input  logic              en_sb_i,
  input  logic              en_nc_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ATTR_W-1:0] attr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [MID_W-1:0]  mid_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ATTR_W-1:0] attr_o,
  output logic [DATA_W-1:0] data_o,
  output logic [MID_W-1:0]  mid_o,
  output logic              nc_o
);

  logic              take;
  logic              nc_d;
  logic [ADDR_W-1:0] addr_q;
  logic [ATTR_W-1:0] attr_q;
  logic [DATA_W-1:0] data_q;
  logic [MID_W-1:0]  mid_q;
  logic              nc_q;

  always_comb begin
    take = (nc_i & en_nc_i) | (sb_i & en_sb_i);
    // a reported non-correctable event outranks a correction in the same cycle
    nc_d = nc_i & en_nc_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      attr_q <= '0;
      data_q <= '0;
      mid_q  <= '0;
      nc_q   <= 1'b0;
    end else if (take) begin
      addr_q <= addr_i;
      attr_q <= attr_i;
      data_q <= data_i;
      mid_q  <= mid_i;
      nc_q   <= nc_d;
    end
  end

  assign addr_o = addr_q;
  assign attr_o = attr_q;
  assign data_o = data_q;
  assign mid_o  = mid_q;
  assign nc_o   = nc_q;

endmodule

// File: rtl/ecc_rpt_unit.sv
module ecc_rpt_unit
  import ecc_rpt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int ATTR_W = 8,
  parameter int MID_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ram_sbc_i,
  input  logic              ram_nce_i,
  input  logic [ADDR_W-1:0] ram_addr_i,
  input  logic [ATTR_W-1:0] ram_attr_i,
  input  logic [DATA_W-1:0] ram_data_i,
  input  logic [MID_W-1:0]  ram_mid_i,
  input  logic              fl_sbc_i,
  input  logic              fl_nce_i,
  input  logic [ADDR_W-1:0] fl_addr_i,
  input  logic [ATTR_W-1:0] fl_attr_i,
  input  logic [DATA_W-1:0] fl_data_i,
  input  logic [MID_W-1:0]  fl_mid_i,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              irq_o
);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_sync_q[1];

  // register write decode
  logic            cfg_we;
  logic            stat_we;
  logic [NCLS-1:0] wbits;
  logic [NCLS-1:0] clr;
  logic            unused_wdata;

  always_comb begin
    cfg_we  = reg_we_i && (reg_addr_i == RA_CFG);
    stat_we = reg_we_i && (reg_addr_i == RA_STAT);
    for (int i = 0; i < NCLS; i++) begin
      wbits[i] = reg_wdata_i[CLS_POS[i]];
    end
    clr = stat_we ? wbits : '0;
  end

  assign unused_wdata = ^reg_wdata_i;

  logic [NCLS-1:0] en_q;

  ecc_rpt_enables u_enables (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .we_i   (cfg_we),
    .wbits_i(wbits),
    .en_o   (en_q)
  );

  // per-memory event and access buses
  logic [NMEM-1:0]   ev_sb;
  logic [NMEM-1:0]   ev_nc;
  logic [ADDR_W-1:0] ev_addr [NMEM];
  logic [ATTR_W-1:0] ev_attr [NMEM];
  logic [DATA_W-1:0] ev_data [NMEM];
  logic [MID_W-1:0]  ev_mid  [NMEM];

  assign ev_sb      = {fl_sbc_i, ram_sbc_i};
  assign ev_nc      = {fl_nce_i, ram_nce_i};
  assign ev_addr[0] = ram_addr_i;
  assign ev_addr[1] = fl_addr_i;
  assign ev_attr[0] = ram_attr_i;
  assign ev_attr[1] = fl_attr_i;
  assign ev_data[0] = ram_data_i;
  assign ev_data[1] = fl_data_i;
  assign ev_mid[0]  = ram_mid_i;
  assign ev_mid[1]  = fl_mid_i;

  // gate each event class with its enable
  logic [NCLS-1:0] set;

  always_comb begin
    set = '0;
    for (int m = 0; m < NMEM; m++) begin
      set[MEM_SB_CLS[m]] = ev_sb[m] & en_q[MEM_SB_CLS[m]];
      set[MEM_NC_CLS[m]] = ev_nc[m] & en_q[MEM_NC_CLS[m]];
    end
  end

  logic [NCLS-1:0] flag_q;
  logic            flag_any;

  ecc_rpt_flags u_flags (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .set_i (set),
    .clr_i (clr),
    .flag_o(flag_q),
    .any_o (flag_any)
  );

  assign irq_o = flag_any;

  // capture records, one per memory
  logic [ADDR_W-1:0] cap_addr [NMEM];
  logic [ATTR_W-1:0] cap_attr [NMEM];
  logic [DATA_W-1:0] cap_data [NMEM];
  logic [MID_W-1:0]  cap_mid  [NMEM];
  logic [NMEM-1:0]   cap_nc;

  for (genvar m = 0; m < NMEM; m++) begin : g_cap
    ecc_rpt_capture #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W),
      .ATTR_W(ATTR_W),
      .MID_W (MID_W)
    ) u_cap (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .sb_i   (ev_sb[m]),
      .nc_i   (ev_nc[m]),
      .en_sb_i(en_q[MEM_SB_CLS[m]]),
      .en_nc_i(en_q[MEM_NC_CLS[m]]),
      .addr_i (ev_addr[m]),
      .attr_i (ev_attr[m]),
      .data_i (ev_data[m]),
      .mid_i  (ev_mid[m]),
      .addr_o (cap_addr[m]),
      .attr_o (cap_attr[m]),
      .data_o (cap_data[m]),
      .mid_o  (cap_mid[m]),
      .nc_o   (cap_nc[m])
    );
  end

  // read mux
  logic [REG_DW-1:0] info_w [NMEM];

  always_comb begin
    for (int m = 0; m < NMEM; m++) begin
      info_w[m] = '0;
      info_w[m][INFO_ATTR_LSB +: ATTR_W] = cap_attr[m];
      info_w[m][INFO_MID_LSB +: MID_W]   = cap_mid[m];
      info_w[m][INFO_NC_BIT]             = cap_nc[m];
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      RA_CFG: begin
        for (int i = 0; i < NCLS; i++) reg_rdata_o[CLS_POS[i]] = en_q[i];
      end
      RA_STAT: begin
        for (int i = 0; i < NCLS; i++) reg_rdata_o[CLS_POS[i]] = flag_q[i];
      end
      RA_RAM_ADDR: reg_rdata_o[ADDR_W-1:0] = cap_addr[0];
      RA_RAM_INFO: reg_rdata_o             = info_w[0];
      RA_RAM_DATA: reg_rdata_o[DATA_W-1:0] = cap_data[0];
      RA_FL_ADDR:  reg_rdata_o[ADDR_W-1:0] = cap_addr[1];
      RA_FL_INFO:  reg_rdata_o             = info_w[1];
      RA_FL_DATA:  reg_rdata_o[DATA_W-1:0] = cap_data[1];
      default:     reg_rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/ecc_rpt_unit_chk.sv
module ecc_rpt_unit_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ram_sbc_i,
  input logic              ram_nce_i,
  input logic              fl_sbc_i,
  input logic              fl_nce_i,
  input logic [3:0]        en_q,
  input logic [3:0]        flag_q,
  input logic              irq_o,
  input logic              reg_we_i,
  input logic [2:0]        reg_addr_i,
  input logic [31:0]       reg_wdata_i,
  input logic [ADDR_W-1:0] ram_cap_addr,
  input logic [ADDR_W-1:0] fl_cap_addr
);

  logic stat_wr;
  logic ram_take;
  logic fl_take;
  logic any_set;

  assign stat_wr  = reg_we_i && (reg_addr_i == 3'd1);
  assign ram_take = (ram_sbc_i && en_q[3]) || (ram_nce_i && en_q[1]);
  assign fl_take  = (fl_sbc_i && en_q[2]) || (fl_nce_i && en_q[0]);
  assign any_set  = ram_take || fl_take;

  a_r2_ram_sb_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_sbc_i && en_q[3]) |=> flag_q[3]);

  a_r3_fl_sb_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_sbc_i && en_q[2]) |=> flag_q[2]);

  a_r4_ram_nc_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_nce_i && en_q[1]) |=> flag_q[1]);

  a_r4_fl_nc_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_nce_i && en_q[0]) |=> flag_q[0]);

  a_r6_no_ram_sb_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q[3] && !(ram_sbc_i && en_q[3])) |=> !flag_q[3]);

  a_r6_no_fl_nc_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q[0] && !(fl_nce_i && en_q[0])) |=> !flag_q[0]);

  a_r6_ram_cap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_take |=> $stable(ram_cap_addr));

  a_r6_fl_cap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_take |=> $stable(fl_cap_addr));

  a_r7_ram_sb_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q[3] && !(stat_wr && reg_wdata_i[5])) |=> flag_q[3]);

  a_r7_fl_nc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q[0] && !(stat_wr && reg_wdata_i[0])) |=> flag_q[0]);

  a_r8_irq_rise_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(any_set));

  a_r8_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !stat_wr) |=> irq_o);

endmodule

bind ecc_rpt_unit ecc_rpt_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .ram_sbc_i   (ram_sbc_i),
  .ram_nce_i   (ram_nce_i),
  .fl_sbc_i    (fl_sbc_i),
  .fl_nce_i    (fl_nce_i),
  .en_q        (en_q),
  .flag_q      (flag_q),
  .irq_o       (irq_o),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .ram_cap_addr(cap_addr[0]),
  .fl_cap_addr (cap_addr[1])
);

// File: tb/ecc_rpt_unit_tb.sv
module ecc_rpt_unit_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        ram_sbc_i, ram_nce_i, fl_sbc_i, fl_nce_i;
  logic [31:0] ram_addr_i, fl_addr_i, ram_data_i, fl_data_i;
  logic [7:0]  ram_attr_i, fl_attr_i;
  logic [3:0]  ram_mid_i, fl_mid_i;
  logic        reg_we_i;
  logic [2:0]  reg_addr_i;
  logic [31:0] reg_wdata_i;
  logic [31:0] reg_rdata_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  ecc_rpt_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .ram_sbc_i(ram_sbc_i), .ram_nce_i(ram_nce_i), .ram_addr_i(ram_addr_i),
    .ram_attr_i(ram_attr_i), .ram_data_i(ram_data_i), .ram_mid_i(ram_mid_i),
    .fl_sbc_i(fl_sbc_i), .fl_nce_i(fl_nce_i), .fl_addr_i(fl_addr_i),
    .fl_attr_i(fl_attr_i), .fl_data_i(fl_data_i), .fl_mid_i(fl_mid_i),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model, register images as software sees them
  logic [31:0] m_cfg, m_stat;
  logic [31:0] m_addr [2];
  logic [31:0] m_info [2];
  logic [31:0] m_data [2];

  function automatic logic [31:0] mk_info(logic nc, logic [3:0] mid, logic [7:0] attr);
    return ({31'd0, nc} << 16) | ({28'd0, mid} << 8) | {24'd0, attr};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cfg = 0; m_stat = 0;
      for (int k = 0; k < 2; k++) begin m_addr[k] = 0; m_info[k] = 0; m_data[k] = 0; end
    end else begin
      logic [31:0] ns;
      ns = m_stat;
      if (reg_we_i && reg_addr_i == 3'd1) ns = ns & ~(reg_wdata_i & 32'h33);
      if (ram_sbc_i && m_cfg[5]) ns[5] = 1'b1;
      if (fl_sbc_i  && m_cfg[4]) ns[4] = 1'b1;
      if (ram_nce_i && m_cfg[1]) ns[1] = 1'b1;
      if (fl_nce_i  && m_cfg[0]) ns[0] = 1'b1;
      if (ram_nce_i && m_cfg[1]) begin
        m_addr[0] = ram_addr_i; m_data[0] = ram_data_i; m_info[0] = mk_info(1'b1, ram_mid_i, ram_attr_i);
      end else if (ram_sbc_i && m_cfg[5]) begin
        m_addr[0] = ram_addr_i; m_data[0] = ram_data_i; m_info[0] = mk_info(1'b0, ram_mid_i, ram_attr_i);
      end
      if (fl_nce_i && m_cfg[0]) begin
        m_addr[1] = fl_addr_i; m_data[1] = fl_data_i; m_info[1] = mk_info(1'b1, fl_mid_i, fl_attr_i);
      end else if (fl_sbc_i && m_cfg[4]) begin
        m_addr[1] = fl_addr_i; m_data[1] = fl_data_i; m_info[1] = mk_info(1'b0, fl_mid_i, fl_attr_i);
      end
      if (reg_we_i && reg_addr_i == 3'd0) m_cfg = reg_wdata_i & 32'h33;
      m_stat = ns;
    end
  end

  function automatic logic [31:0] model_read(logic [2:0] a);
    case (a)
      3'd0: return m_cfg;
      3'd1: return m_stat;
      3'd2: return m_addr[0];
      3'd3: return m_info[0];
      3'd4: return m_data[0];
      3'd5: return m_addr[1];
      3'd6: return m_info[1];
      default: return m_data[1];
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  task automatic compare();
    string tag;
    tag = (reg_addr_i == 3'd0) ? "R1" : (reg_addr_i == 3'd1) ? "R7" : "R5";
    check(tag, reg_rdata_o, model_read(reg_addr_i));
    check("R8", {31'd0, irq_o}, {31'd0, m_stat != 0});
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #1;
    d = reg_rdata_o;
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    tick();
    reg_we_i = 1'b0; reg_wdata_i = 0;
  endtask

  task automatic set_ram(logic sb, logic nc, logic [31:0] a, logic [7:0] at, logic [3:0] mid, logic [31:0] d);
    ram_sbc_i = sb; ram_nce_i = nc; ram_addr_i = a; ram_attr_i = at; ram_mid_i = mid; ram_data_i = d;
  endtask

  task automatic set_fl(logic sb, logic nc, logic [31:0] a, logic [7:0] at, logic [3:0] mid, logic [31:0] d);
    fl_sbc_i = sb; fl_nce_i = nc; fl_addr_i = a; fl_attr_i = at; fl_mid_i = mid; fl_data_i = d;
  endtask

  task automatic idle();
    ram_sbc_i = 0; ram_nce_i = 0; fl_sbc_i = 0; fl_nce_i = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 0; reg_we_i = 0; reg_addr_i = 0; reg_wdata_i = 0;
    idle();
    set_ram(0, 0, 0, 0, 0, 0);
    set_fl(0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) tick();

    // R1: reset state
    rd(3'd0, d); check("R1 cfg reset", d, 32'h0);
    rd(3'd1, d); check("R7 stat reset", d, 32'h0);
    check("R8 irq reset", {31'd0, irq_o}, 32'd0);

    // R6: disabled RAM correction leaves flags and record untouched
    set_ram(1, 0, 32'h0000_0A10, 8'h77, 4'h2, 32'h0BAD_0BAD);
    tick(); idle();
    rd(3'd1, d); check("R6 stat", d, 32'h0);
    rd(3'd2, d); check("R6 ram addr", d, 32'h0);
    check("R6 irq", {31'd0, irq_o}, 32'd0);

    // R1: only the four enable bits are writable
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, d); check("R1 cfg mask", d, 32'h33);

    // R2 / R5: RAM correction with only its enable set
    wr(3'd0, 32'h20);
    set_ram(1, 0, 32'h0000_1000, 8'h5A, 4'h3, 32'hDEAD_BEEF);
    tick(); idle();
    rd(3'd1, d); check("R2 stat", d, 32'h20);
    check("R8 irq up", {31'd0, irq_o}, 32'd1);
    rd(3'd2, d); check("R5 ram addr", d, 32'h1000);
    rd(3'd3, d); check("R5 ram info", d, 32'h035A);
    rd(3'd4, d); check("R5 ram data", d, 32'hDEAD_BEEF);

    // R6: flash correction with its enable clear
    set_fl(1, 0, 32'h0000_0F00, 8'h44, 4'h6, 32'h1111_2222);
    tick(); idle();
    rd(3'd1, d); check("R6 fl stat", d, 32'h20);
    rd(3'd5, d); check("R6 fl addr", d, 32'h0);

    // R7: writing zero does nothing, writing one clears
    wr(3'd1, 32'h0);
    rd(3'd1, d); check("R7 w0", d, 32'h20);
    wr(3'd1, 32'h20);
    rd(3'd1, d); check("R7 w1c", d, 32'h0);
    check("R8 irq down", {31'd0, irq_o}, 32'd0);

    // R9: simultaneous correction and non-correctable on RAM
    wr(3'd0, 32'h33);
    set_ram(1, 1, 32'h0000_2000, 8'h11, 4'h5, 32'h1234_5678);
    tick(); idle();
    rd(3'd1, d); check("R9 stat", d, 32'h22);
    rd(3'd3, d); check("R9 ram info", d, 32'h0001_0511);

    // R4 / R5: flash non-correctable, separate record
    set_fl(0, 1, 32'h0000_3000, 8'h22, 4'h7, 32'hCAFE_F00D);
    tick(); idle();
    rd(3'd1, d); check("R4 stat", d, 32'h23);
    rd(3'd5, d); check("R5 fl addr", d, 32'h3000);
    rd(3'd6, d); check("R5 fl info", d, 32'h0001_0722);
    rd(3'd7, d); check("R5 fl data", d, 32'hCAFE_F00D);

    // R3 / R10: later flash correction overwrites the flash record only
    set_fl(1, 0, 32'h0000_3004, 8'h33, 4'h1, 32'h0000_0001);
    tick(); idle();
    rd(3'd1, d); check("R3 stat", d, 32'h33);
    rd(3'd5, d); check("R10 fl addr", d, 32'h3004);
    rd(3'd6, d); check("R10 fl info", d, 32'h0133);
    rd(3'd2, d); check("R5 ram kept", d, 32'h2000);

    // R4: RAM non-correctable alone, no other handshake needed
    wr(3'd1, 32'h33);
    set_ram(0, 1, 32'h0000_4000, 8'h01, 4'h9, 32'h5555_AAAA);
    tick(); idle();
    rd(3'd1, d); check("R4 ram nc stat", d, 32'h02);
    rd(3'd3, d); check("R4 ram nc info", d, 32'h0001_0901);

    // R7: set wins over clear in the same cycle
    reg_we_i = 1; reg_addr_i = 3'd1; reg_wdata_i = 32'h22;
    set_ram(1, 0, 32'h0000_5000, 8'h02, 4'h4, 32'h0);
    tick(); idle(); reg_we_i = 0; reg_wdata_i = 0;
    rd(3'd1, d); check("R7 set wins", d, 32'h20);
    wr(3'd1, 32'h20);
    rd(3'd1, d); check("R7 final clear", d, 32'h0);
    check("R8 irq final", {31'd0, irq_o}, 32'd0);

    // mixed traffic swept against the model on every clock
    for (int n = 0; n < 200; n++) begin
      reg_addr_i = 3'(n % 8);
      reg_we_i   = (n % 7 == 3);
      reg_wdata_i = (n % 14 == 3) ? 32'h33 : 32'(n * 5);
      if (n % 14 == 10) begin reg_we_i = 1; reg_addr_i = 3'd0; reg_wdata_i = 32'(n); end
      set_ram(n % 3 == 0, n % 5 == 0, 32'(n * 16), 8'(n), 4'(n), 32'(n * 977));
      set_fl(n % 4 == 1, n % 6 == 2, 32'(n * 32), 8'(n + 3), 4'(n + 1), 32'(n * 131));
      tick();
    end
    idle(); reg_we_i = 0;
    tick();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule